// File: doc/BRIEF.md
# Read-Only Display-Data Serial Slave Port

This block is a two-wire serial slave that lets one display-data channel read a private 256-byte bank. SCL and SDA arrive as plain inputs and are sampled in the system clock domain. The block drives SDA through an open-drain enable, where a high enable pulls the line low. The bank sits outside the block and is reached through a read port: the block presents a byte address and takes the byte back combinationally.

A master reads in three ways. A random read is a write command that carries one word address, then a repeated START and a read command. A current read is a read command alone, served from the internal address counter. A sequential read continues either of these for as long as the master acknowledges. The port never accepts data writes. It answers only while the shared write-protect input is low.

Top module: `ddc_rd_port`

## Requirements
- R1: The device byte 1010_000 followed by the R/W bit (0xA0 for write, 0xA1 for read) is acknowledged by holding SDA low during the ninth clock. Any other device byte, such as 0xA2 or 0xB1, gets no acknowledge.
- R2: While `wp_i` is high the port acknowledges nothing. If `wp_i` rises during a transfer, SDA is released on the next cycle.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bytes clocked before any START are ignored. A START in any state restarts device-byte reception. A STOP in any state returns the port to idle with SDA released.
- R4: SDA is sampled on rising SCL edges. The SDA enable only asserts after a falling SCL edge, never while SCL is high.
- R5: After 0xA0, the port acknowledges one word-address byte and loads it into the address counter. Any further bytes in that command are not acknowledged and leave the counter unchanged.
- R6: A read command returns, MSB first, the bank byte at the counter, so a random read returns the byte at the word address just given.
- R7: Each master acknowledge after a data byte makes the port send the next byte. The counter wraps from 0xFF to 0x00.
- R8: After a master no-acknowledge the port releases SDA and sends nothing more until the next START.
- R9: After any read byte the counter holds that byte's address plus one, so a following current read returns the next byte.
- R10: After reset SDA is released and the counter is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| wp_i | input | 1 | Shared write-protect; port enabled only while low |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| mem_addr | output | 8 | Bank read address (address counter) |
| mem_data | input | 8 | Bank read data for `mem_addr` |

## Verification
Two kinds of event can fall on the same system cycle as a transfer. The first is a line condition (START, STOP or write-protect) arriving while a byte is in flight. The second is the address-counter step that happens at the master's acknowledge clock. The bench provokes the first by issuing a repeated START after three bits of a device byte, a STOP in the middle of a device byte, and a write-protect rise while the port is shifting data out. It judges each case by the acknowledge and data seen on later transfers and by SDA being released. The counter step is checked across the 0xFF boundary: a sequential read at 0xFD ends with a no-acknowledge at 0x00, and a current read follows it.

// File: rtl/ddc_rd_pkg.sv
// Package: shared constants and state encoding for the read-only serial port.
// Assumes one byte per transfer and a byte-wide bank.
package ddc_rd_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for START
        ST_DEV,       // shifting in device byte
        ST_DEV_ACK,   // acknowledging device byte
        ST_WORD,      // shifting in word address
        ST_WORD_ACK,  // acknowledging word address
        ST_TX,        // shifting out data byte
        ST_MACK       // sampling master acknowledge
    } port_st_t;
endpackage

// File: rtl/ddc_line_watch.sv
// Module: synchronises SCL/SDA into the system clock and flags SCL edges,
// START and STOP as single-cycle pulses. Assumes the system clock is many
// times faster than SCL so each line phase spans several samples.
module ddc_line_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_p;
    logic                   sda_p;

    // Synchroniser chains, idle-high reset
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sh[g] <= 1'b1;
                    sda_sh[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_sh[g] <= scl_i;
                    sda_sh[g] <= sda_i;
                end else begin
                    scl_sh[g] <= scl_sh[g-1];
                    sda_sh[g] <= sda_sh[g-1];
                end
            end
        end
    endgenerate

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    // Previous-sample registers for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Event decode from current and previous samples
    always_comb begin
        scl_rise = scl_s & ~scl_p;
        scl_fall = ~scl_s & scl_p;
        start_p  = scl_s & scl_p & sda_p & ~sda_s;
        stop_p   = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/ddc_read_engine.sv
// Module: byte-level protocol engine. Receives device and word-address bytes,
// keeps the address counter and shifts bank data out. Assumes single-cycle
// event pulses from the line watcher and a combinational bank read port.
module ddc_read_engine
    import ddc_rd_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [6:0]  DEV_ADDR = 7'b1010000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_i,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic [BYTE_W-1:0] mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              sda_oe
);
    port_st_t          st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [ADDR_W-1:0] addr_q;
    logic              rw_q;
    logic              mack_q;

    assign mem_addr = addr_q;

    // Protocol state, shifters, counter and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            addr_q <= '0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
            sda_oe <= 1'b0;
        end else if (wp_i) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (start_p) begin
            st     <= ST_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop_p) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (scl_rise) begin
            case (st)
                ST_DEV, ST_WORD: begin
                    rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                    cnt   <= cnt + 1'b1;
                end
                ST_TX:   cnt <= cnt + 1'b1;
                ST_MACK: begin
                    mack_q <= ~sda_s;
                    addr_q <= addr_q + 1'b1;
                end
                default: ;
            endcase
        end else if (scl_fall) begin
            case (st)
                ST_DEV: if (cnt == CNT_W'(BYTE_W)) begin
                    if (rx_sh[BYTE_W-1:1] == DEV_ADDR) begin
                        sda_oe <= 1'b1;
                        rw_q   <= rx_sh[0];
                        st     <= ST_DEV_ACK;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_DEV_ACK: begin
                    cnt <= '0;
                    if (rw_q) begin
                        tx_sh  <= mem_data;
                        sda_oe <= ~mem_data[BYTE_W-1];
                        st     <= ST_TX;
                    end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_WORD;
                    end
                end
                ST_WORD: if (cnt == CNT_W'(BYTE_W)) begin
                    addr_q <= rx_sh[ADDR_W-1:0];
                    sda_oe <= 1'b1;
                    st     <= ST_WORD_ACK;
                end
                ST_WORD_ACK: begin
                    sda_oe <= 1'b0;
                    st     <= ST_IDLE;
                end
                ST_TX: if (cnt == CNT_W'(BYTE_W)) begin
                    sda_oe <= 1'b0;
                    st     <= ST_MACK;
                end else begin
                    tx_sh  <= tx_sh << 1;
                    sda_oe <= ~tx_sh[BYTE_W-2];
                end
                ST_MACK: if (mack_q) begin
                    cnt    <= '0;
                    tx_sh  <= mem_data;
                    sda_oe <= ~mem_data[BYTE_W-1];
                    st     <= ST_TX;
                end else begin
                    sda_oe <= 1'b0;
                    st     <= ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    // R4
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R2
    wp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp_i |=> !sda_oe);

    // R3
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (!sda_oe && st == ST_IDLE));

    // R7
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MACK && scl_rise && !wp_i && !start_p && !stop_p && addr_q == '1)
        |=> addr_q == '0);

    // R1
    dev_ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DEV_ACK) |-> sda_oe);
endmodule

// File: rtl/ddc_rd_port.sv
// Module: top of the read-only display-data serial slave port. Joins the
// line watcher and the protocol engine. Assumes an external 2^ADDR_W-byte
// bank with combinational read and an open-drain pad driven by sda_oe.
module ddc_rd_port #(
    parameter int         ADDR_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'b1010000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wp_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_data
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;

    ddc_line_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p)
    );

    ddc_read_engine #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p),
        .stop_p(stop_p), .mem_data(mem_data), .mem_addr(mem_addr),
        .sda_oe(sda_oe)
    );
endmodule

// File: tb/sim_ddc_rd_port.sv
// Bench: bus-master tasks drive SCL/SDA, push expected values into a queue
// and report observed ones; a monitor pops and compares both.
module sim_ddc_rd_port;
    localparam int H = 8;  // system clocks per SCL phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       wp = 1'b0;
    logic       sda_oe;
    logic [7:0] mem_addr;
    logic [7:0] mem_data;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    int oe_rise_hi = 0;
    logic oe_d = 1'b0;

    int    exp_v[$];
    string exp_t[$];
    int    got_v[$];

    always #2 clk = ~clk;

    function automatic logic [7:0] memf(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'hA5;
    endfunction

    assign mem_data = memf(mem_addr);
    assign sda_line = m_sda & ~sda_oe;

    ddc_rd_port u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .wp_i(wp),
        .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    // Monitor: compares observed results against expectations in order
    initial forever begin
        @(negedge clk);
        while (got_v.size() > 0 && exp_v.size() > 0) begin
            int g, e;
            string t;
            g = got_v.pop_front();
            e = exp_v.pop_front();
            t = exp_t.pop_front();
            checks++;
            if (g != e) begin
                errors++;
                $display("FAIL %s: got 0x%0h expected 0x%0h", t, g, e);
            end
        end
    end

    // R4 side check: count enable rises while SCL is high
    always @(negedge clk) begin
        if (sda_oe && !oe_d && m_scl) oe_rise_hi++;
        oe_d <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_v(input int v, input string tag);
        exp_v.push_back(v);
        exp_t.push_back(tag);
    endtask

    task automatic direct(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(H);
            m_scl = 1'b1; tick(H);
            m_scl = 1'b0;
        end
    endtask

    // Sends a byte and reports the acknowledge (1 = slave pulled low)
    task automatic send_byte(input logic [7:0] b);
        logic ack;
        send_bits(b, 8);
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H / 2);
        ack = ~sda_line;
        tick(H / 2);
        m_scl = 1'b0;
        got_v.push_back(int'(ack));
    endtask

    // Receives a byte, then answers with ack (1) or no-ack (0)
    task automatic recv_byte(input logic mack);
        logic [7:0] b = '0;
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(H);
            m_scl = 1'b1; tick(H / 2);
            b = {b[6:0], sda_line};
            tick(H / 2);
            m_scl = 1'b0;
        end
        m_sda = ~mack; tick(H);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(1);
        m_sda = 1'b1;
        got_v.push_back(int'(b));
    endtask

    initial begin
        tick(5);
        // R10: reset state
        direct(int'(sda_oe), 0, "R10 sda released in reset");
        rst_n = 1'b1; tick(3);
        direct(int'(sda_oe), 0, "R10 sda released after reset");
        direct(int'(mem_addr), 0, "R10 counter zero");

        // R5: load word address, data byte refused
        bus_start;
        expect_v(1, "R1 0xA0 acked");        send_byte(8'hA0);
        expect_v(1, "R5 word address acked"); send_byte(8'h10);
        expect_v(0, "R5 data byte not acked"); send_byte(8'h33);
        bus_stop;

        // R6: current read from loaded address
        bus_start;
        expect_v(1, "R1 0xA1 acked");        send_byte(8'hA1);
        expect_v(memf(8'h10), "R6 read at 0x10"); recv_byte(1'b0);
        bus_stop;

        // R9 + R8: next current read, then silence after no-ack
        bus_start;
        expect_v(1, "R1 0xA1 acked");        send_byte(8'hA1);
        expect_v(memf(8'h11), "R9 read last+1"); recv_byte(1'b0);
        expect_v(8'hFF, "R8 released after no-ack"); recv_byte(1'b0);
        bus_stop;

        // R6 + R7: random read at 0xFD, sequential across wrap
        bus_start;
        expect_v(1, "R1 0xA0 acked");        send_byte(8'hA0);
        expect_v(1, "R5 word address acked"); send_byte(8'hFD);
        bus_start;
        expect_v(1, "R1 0xA1 acked");        send_byte(8'hA1);
        expect_v(memf(8'hFD), "R6 random read 0xFD"); recv_byte(1'b1);
        expect_v(memf(8'hFE), "R7 sequential 0xFE"); recv_byte(1'b1);
        expect_v(memf(8'hFF), "R7 sequential 0xFF"); recv_byte(1'b1);
        expect_v(memf(8'h00), "R7 wrap to 0x00");   recv_byte(1'b0);
        bus_stop;

        // R1: wrong device bytes
        bus_start;
        expect_v(0, "R1 0xA2 refused"); send_byte(8'hA2);
        bus_start;
        expect_v(0, "R1 0xB1 refused"); send_byte(8'hB1);
        bus_stop;

        // R2: write-protect high blocks acknowledge
        wp = 1'b1; tick(2);
        bus_start;
        expect_v(0, "R2 no ack while protected"); send_byte(8'hA1);
        bus_stop;
        wp = 1'b0; tick(2);

        // R3: byte without START ignored
        expect_v(0, "R3 no ack before START"); send_byte(8'hA1);
        bus_stop;

        // R3: repeated START mid-byte restarts reception
        bus_start;
        send_bits(8'hA1, 3);
        bus_start;
        expect_v(1, "R3 restart acked"); send_byte(8'hA1);
        expect_v(memf(8'h01), "R9 read 0x01 after wrap"); recv_byte(1'b0);
        bus_stop;

        // R3: STOP mid device byte returns to idle
        bus_start;
        send_bits(8'hA1, 4);
        bus_stop;
        tick(4);
        direct(int'(sda_oe), 0, "R3 released after STOP");
        bus_start;
        expect_v(1, "R3 acked after STOP"); send_byte(8'hA1);
        // R2: protect rises while data shifts out
        m_sda = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0;
        end
        wp = 1'b1; tick(3);
        direct(int'(sda_oe), 0, "R2 released on protect");
        for (int i = 0; i < 6; i++) begin
            tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0;
        end
        bus_stop;
        wp = 1'b0; tick(2);

        // R4: enable never rose with SCL high
        direct(oe_rise_hi, 0, "R4 enable rises only with SCL low");

        tick(10);
        direct(exp_v.size(), 0, "R6 all expected results observed");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        tick(150000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule